// File: doc/BRIEF.md
# Root Port Reset Sequencer

This block runs the reset handshake for one root port of a USB 2.0 host controller. It does this entirely through the controller's 32-bit register bus. A start pulse and a port number begin a run. The sequencer first polls the controller status register for a port-change indication and retries a bounded number of times. It then reads the port's status/control register and writes it back with reset raised and enable dropped. After that it polls the port on a fixed millisecond schedule until one of four verdicts is reached.

When the hardware leaves the reset bit stuck at a check, the sequencer writes the register again with reset lowered, which forces the reset to end. It then re-polls a limited number of times. Each write is built so that the write-one-to-clear change flags are never acknowledged by accident. All waiting is counted in millisecond ticks from an internal prescaler. The run ends with a one-cycle done pulse and a two-bit result code.

Top module: `port_reset_seq`

## Requirements
- R1: A start with port number 0 or above `NPORTS` makes no bus access and gives a done pulse with result invalid (2) on the cycle after the start.
- R2: Before touching the port, the block waits `SETTLE_MS` and reads the status register at `STS_ADDR`. If bit 2 is set it proceeds. Otherwise it waits and reads again, and after `SETTLE_TRIES` (3) reads without bit 2 it finishes with not-connected (1).
- R3: The port register sits at `PORT_BASE + 4*(port-1)`. The first port write is the value just read with bit 8 (reset) set and bit 2 (enable) cleared. In this write, and in every other port write, bits 1, 3 and 5 (write-one-to-clear) are zero and all other bits are preserved.
- R4: After the reset write, the port is read every `STEP_MS` (50 ms). A read with bit 8 clear and bit 2 set finishes with success (0).
- R5: A read with bit 0 (connect) clear finishes with not-connected (1). This outcome takes priority over every other outcome.
- R6: A read with bit 0 set and bit 1 (connect change) set finishes with invalid (2).
- R7: If bit 8 is still set at a periodic check, the block writes the read value with bits 8, 1, 3 and 5 cleared. It then re-reads up to 2 more times at `STEP_MS` spacing, makes no further write, and judges the last read by R4 to R6.
- R8: Every wait of `STEP_MS` counts toward a total. If a judged read gives no verdict and the total has reached `LIMIT_MS` (500), the result is busy (3).
- R9: `done` is a one-cycle pulse. Result codes are success 0, not-connected 1, invalid 2, busy 3. A start pulse that arrives during a run is ignored.
- R10: At most one of `regRd` and `regWr` is high in a cycle. Read data is taken on the cycle after `regRd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| portIdx | input | IDX_W | Port number, 1-based |
| regRd | output | 1 | Register read strobe |
| regWr | output | 1 | Register write strobe |
| regAddr | output | ADDR_W | Register byte address |
| regWdata | output | 32 | Register write data |
| regRdata | input | 32 | Read data, valid the cycle after `regRd` |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | Verdict: 0 success, 1 not-connected, 2 invalid, 3 busy |

## Verification
Some rules are checked on every cycle by the assertions. These are: the write-one-to-clear bits are zero in every write, a reset-raising write never also sets enable, reads and writes never overlap, the done pulse lasts one cycle, a bad port number is rejected at once, and busy is only reported once the limit is reached. Other behaviour can only be shown by the bench's scripted port responses. That covers the verdict chosen for each register pattern, the priority of disconnect over connect change, the forced-release write value, the exact number of rechecks, and the arrival time of each verdict in milliseconds.

// File: rtl/prs_pkg.sv
package prs_pkg;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_NOCONN  = 2'd1,
    RES_INVALID = 2'd2,
    RES_BUSY    = 2'd3
  } resCode_e;

  // Port register bit positions (decoded by the controller hardware)
  localparam int BIT_CONN = 0;
  localparam int BIT_CSC  = 1;
  localparam int BIT_PE   = 2;
  localparam int BIT_RST  = 8;
  // Status register: port-change indication
  localparam int BIT_PCD  = 2;
  // Write-one-to-clear flags: connect change, enable change, over-current change
  localparam logic [31:0] W1C_MASK = 32'h0000_002A;
  localparam logic [31:0] PE_MASK  = 32'h0000_0004;
  localparam logic [31:0] RST_MASK = 32'h0000_0100;

  typedef struct packed {
    logic latchIdx;
    logic clrProgress;
    logic loadSettle;
    logic loadStep;
    logic bumpTry;
    logic armRecheck;
    logic useRecheck;
    logic rdStatus;
    logic rdPort;
    logic latchPort;
    logic wrAssert;
    logic wrRelease;
  } ctlStrobe_t;

endpackage

// File: rtl/prs_datapath.sv
module prs_datapath
  import prs_pkg::*;
#(
  parameter int NPORTS         = 4,
  parameter int IDX_W          = 3,
  parameter int ADDR_W         = 12,
  parameter int PORT_BASE      = 'h44,
  parameter int STS_ADDR       = 'h04,
  parameter int TICK_DIV       = 100000,
  parameter int SETTLE_MS      = 100,
  parameter int SETTLE_TRIES   = 3,
  parameter int STEP_MS        = 50,
  parameter int LIMIT_MS       = 500,
  parameter int FORCE_RECHECKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [IDX_W-1:0]  portIdx,
  input  logic [31:0]       regRdata,
  output logic              idxValid,
  output logic              timerDone,
  output logic              tryLast,
  output logic              recheckMore,
  output logic              limitHit,
  output logic              regRd,
  output logic              regWr,
  output logic [ADDR_W-1:0] regAddr,
  output logic [31:0]       regWdata
);

  localparam int MAXWAIT = (SETTLE_MS > STEP_MS) ? SETTLE_MS : STEP_MS;
  localparam int TW      = $clog2(MAXWAIT + 1);
  localparam int PW      = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam int ELW     = $clog2(LIMIT_MS + (FORCE_RECHECKS + 1) * STEP_MS + 1);
  localparam int TRW     = $clog2(SETTLE_TRIES + 1);
  localparam int RCW     = $clog2(FORCE_RECHECKS + 1);

  logic [IDX_W-1:0] idxQ;
  logic [TW-1:0]    msLeft;
  logic [PW-1:0]    preCnt;
  logic [ELW-1:0]   elapsedMs;
  logic [TRW-1:0]   tries;
  logic [RCW-1:0]   rechecks;
  logic [31:0]      portWord;
  logic [ADDR_W-1:0] portAddr;

  assign idxValid = (portIdx != '0) && (int'(portIdx) <= NPORTS);

  always_ff @(posedge clk) begin
    if (!rstN) idxQ <= '0;
    else if (ctl.latchIdx) idxQ <= portIdx;
  end

  // Millisecond timer with its own prescaler, restarted on every load
  always_ff @(posedge clk) begin
    if (!rstN) begin
      msLeft <= '0;
      preCnt <= '0;
    end else if (ctl.loadSettle) begin
      msLeft <= TW'(SETTLE_MS);
      preCnt <= '0;
    end else if (ctl.loadStep) begin
      msLeft <= TW'(STEP_MS);
      preCnt <= '0;
    end else if (msLeft != '0) begin
      if (preCnt == PW'(TICK_DIV - 1)) begin
        preCnt <= '0;
        msLeft <= msLeft - 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end
  assign timerDone = (msLeft == '0);

  // Accumulated reset-phase wait, counted when each step wait is armed
  always_ff @(posedge clk) begin
    if (!rstN || ctl.clrProgress) elapsedMs <= '0;
    else if (ctl.loadStep) elapsedMs <= elapsedMs + ELW'(STEP_MS);
  end
  assign limitHit = (int'(elapsedMs) >= LIMIT_MS);

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clrProgress) tries <= '0;
    else if (ctl.bumpTry) tries <= tries + 1'b1;
  end
  assign tryLast = (int'(tries) == SETTLE_TRIES - 1);

  always_ff @(posedge clk) begin
    if (!rstN) rechecks <= '0;
    else if (ctl.armRecheck) rechecks <= RCW'(FORCE_RECHECKS);
    else if (ctl.useRecheck && rechecks != '0) rechecks <= rechecks - 1'b1;
  end
  assign recheckMore = (rechecks != '0);

  always_ff @(posedge clk) begin
    if (!rstN) portWord <= '0;
    else if (ctl.latchPort) portWord <= regRdata;
  end

  assign portAddr = ADDR_W'(PORT_BASE) + (ADDR_W'(idxQ - IDX_W'(1)) << 2);

  assign regRd    = ctl.rdStatus | ctl.rdPort;
  assign regWr    = ctl.wrAssert | ctl.wrRelease;
  assign regAddr  = ctl.rdStatus ? ADDR_W'(STS_ADDR) : portAddr;
  assign regWdata = ctl.wrAssert ? ((portWord & ~(W1C_MASK | PE_MASK)) | RST_MASK)
                                 : (portWord & ~(W1C_MASK | RST_MASK));

  AST_W1C_NEVER_SET: assert property (@(posedge clk) disable iff (!rstN)
    regWr |-> ((regWdata & W1C_MASK) == '0)); // R3

  AST_RESET_DROPS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regWdata[BIT_RST]) |-> !regWdata[BIT_PE]); // R3

  AST_SINGLE_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    !(regRd && regWr)); // R10

  AST_ELAPSED_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    int'(elapsedMs) <= LIMIT_MS + (FORCE_RECHECKS + 1) * STEP_MS); // R8

endmodule

// File: rtl/prs_control.sv
module prs_control
  import prs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       idxValid,
  input  logic       timerDone,
  input  logic       tryLast,
  input  logic       recheckMore,
  input  logic       limitHit,
  input  logic       flagConn,
  input  logic       flagCsc,
  input  logic       flagBit2,   // enable on a port read, change-detect on a status read
  input  logic       flagRst,
  output ctlStrobe_t ctl,
  output logic       done,
  output resCode_e   result
);

  typedef enum logic [3:0] {
    S_IDLE, S_SETTLE, S_STS_RD, S_STS_CAP, S_PRT_RD, S_PRT_CAP, S_PRT_WR,
    S_CHK_WAIT, S_CHK_RD, S_CHK_CAP, S_FRC_WR, S_FRC_WAIT, S_FRC_RD, S_FRC_CAP
  } state_e;

  state_e   state, stateNext;
  logic     doneNext;
  resCode_e resNext;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    doneNext  = 1'b0;
    resNext   = RES_OK;
    unique case (state)
      S_IDLE: if (start) begin
        if (!idxValid) begin
          doneNext = 1'b1;
          resNext  = RES_INVALID;
        end else begin
          ctl.latchIdx    = 1'b1;
          ctl.clrProgress = 1'b1;
          ctl.loadSettle  = 1'b1;
          stateNext       = S_SETTLE;
        end
      end
      S_SETTLE:  if (timerDone) stateNext = S_STS_RD;
      S_STS_RD: begin
        ctl.rdStatus = 1'b1;
        stateNext    = S_STS_CAP;
      end
      S_STS_CAP: begin
        if (flagBit2) stateNext = S_PRT_RD;
        else if (tryLast) begin
          doneNext  = 1'b1;
          resNext   = RES_NOCONN;
          stateNext = S_IDLE;
        end else begin
          ctl.bumpTry    = 1'b1;
          ctl.loadSettle = 1'b1;
          stateNext      = S_SETTLE;
        end
      end
      S_PRT_RD: begin
        ctl.rdPort = 1'b1;
        stateNext  = S_PRT_CAP;
      end
      S_PRT_CAP: begin
        ctl.latchPort = 1'b1;
        stateNext     = S_PRT_WR;
      end
      S_PRT_WR: begin
        ctl.wrAssert = 1'b1;
        ctl.loadStep = 1'b1;
        stateNext    = S_CHK_WAIT;
      end
      S_CHK_WAIT: if (timerDone) stateNext = S_CHK_RD;
      S_CHK_RD: begin
        ctl.rdPort = 1'b1;
        stateNext  = S_CHK_CAP;
      end
      S_FRC_WR: begin
        ctl.wrRelease  = 1'b1;
        ctl.armRecheck = 1'b1;
        ctl.loadStep   = 1'b1;
        stateNext      = S_FRC_WAIT;
      end
      S_FRC_WAIT: if (timerDone) stateNext = S_FRC_RD;
      S_FRC_RD: begin
        ctl.rdPort     = 1'b1;
        ctl.useRecheck = 1'b1;
        stateNext      = S_FRC_CAP;
      end
      S_CHK_CAP, S_FRC_CAP: begin
        ctl.latchPort = 1'b1;
        if (state == S_CHK_CAP && flagRst) stateNext = S_FRC_WR;
        else if (state == S_FRC_CAP && flagRst && recheckMore) begin
          ctl.loadStep = 1'b1;
          stateNext    = S_FRC_WAIT;
        end else begin
          // verdict priority: disconnect, connect change, success, limit
          stateNext = S_IDLE;
          doneNext  = 1'b1;
          if (!flagConn)                 resNext = RES_NOCONN;
          else if (flagCsc)              resNext = RES_INVALID;
          else if (!flagRst && flagBit2) resNext = RES_OK;
          else if (limitHit)             resNext = RES_BUSY;
          else begin
            doneNext     = 1'b0;
            ctl.loadStep = 1'b1;
            stateNext    = S_CHK_WAIT;
          end
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      done   <= 1'b0;
      result <= RES_OK;
    end else begin
      state <= stateNext;
      done  <= doneNext;
      if (doneNext) result <= resNext;
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_BAD_INDEX_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && start && !idxValid) |=> (done && result == RES_INVALID)); // R1

  AST_BUSY_ONLY_AT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    (doneNext && resNext == RES_BUSY) |-> limitHit); // R8

  AST_NO_RESTART_MIDRUN: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) |-> !ctl.latchIdx); // R9

endmodule

// File: rtl/port_reset_seq.sv
module port_reset_seq
  import prs_pkg::*;
#(
  parameter int NPORTS         = 4,
  parameter int IDX_W          = $clog2(NPORTS + 1),
  parameter int ADDR_W         = 12,
  parameter int PORT_BASE      = 'h44,
  parameter int STS_ADDR       = 'h04,
  parameter int TICK_DIV       = 100000,
  parameter int SETTLE_MS      = 100,
  parameter int SETTLE_TRIES   = 3,
  parameter int STEP_MS        = 50,
  parameter int LIMIT_MS       = 500,
  parameter int FORCE_RECHECKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [IDX_W-1:0]  portIdx,
  output logic              regRd,
  output logic              regWr,
  output logic [ADDR_W-1:0] regAddr,
  output logic [31:0]       regWdata,
  input  logic [31:0]       regRdata,
  output logic              done,
  output logic [1:0]        result
);

  ctlStrobe_t ctl;
  logic idxValid, timerDone, tryLast, recheckMore, limitHit;
  resCode_e resCode;

  prs_datapath #(
    .NPORTS(NPORTS), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .PORT_BASE(PORT_BASE),
    .STS_ADDR(STS_ADDR), .TICK_DIV(TICK_DIV), .SETTLE_MS(SETTLE_MS),
    .SETTLE_TRIES(SETTLE_TRIES), .STEP_MS(STEP_MS), .LIMIT_MS(LIMIT_MS),
    .FORCE_RECHECKS(FORCE_RECHECKS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .portIdx(portIdx), .regRdata(regRdata),
    .idxValid(idxValid), .timerDone(timerDone), .tryLast(tryLast),
    .recheckMore(recheckMore), .limitHit(limitHit),
    .regRd(regRd), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata)
  );

  prs_control u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .idxValid(idxValid),
    .timerDone(timerDone), .tryLast(tryLast), .recheckMore(recheckMore),
    .limitHit(limitHit),
    .flagConn(regRdata[BIT_CONN]), .flagCsc(regRdata[BIT_CSC]),
    .flagBit2(regRdata[BIT_PE]), .flagRst(regRdata[BIT_RST]),
    .ctl(ctl), .done(done), .result(resCode)
  );

  assign result = resCode;

endmodule

// File: tb/port_reset_seq_tb.sv
module port_reset_seq_tb;

  localparam int DIV   = 8;
  localparam int SLACK = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  portIdx = '0;
  logic        regRd, regWr, done;
  logic [11:0] regAddr;
  logic [31:0] regWdata;
  logic [31:0] regRdata = '0;
  logic [1:0]  result;

  always #5 clk = ~clk;

  port_reset_seq #(.TICK_DIV(DIV)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .portIdx(portIdx),
    .regRd(regRd), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .done(done), .result(result)
  );

  int nChecks = 0;
  int nFail   = 0;
  int cycle   = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ---------------- register model ----------------
  logic [31:0] script [4];
  int scriptLen = 1;
  int portRds = 0, stsRds = 0, pcdAt = 0;
  int nWr = 0, badAddr = 0, overlap = 0, w1cHits = 0;
  logic [11:0] expPortAddr = 12'h44;
  logic [31:0] wrLog [8];

  always @(posedge clk) begin
    cycle <= cycle + 1;
    if (regRd && regWr) overlap <= overlap + 1;
    if (regRd) begin
      if (regAddr == 12'h004) begin
        regRdata <= ((stsRds + 1) == pcdAt) ? 32'h4 : 32'h0;
        stsRds   <= stsRds + 1;
      end else begin
        if (regAddr != expPortAddr) badAddr <= badAddr + 1;
        regRdata <= script[(portRds < scriptLen) ? portRds : scriptLen - 1];
        portRds  <= portRds + 1;
      end
    end
    if (regWr) begin
      if (regAddr != expPortAddr) badAddr <= badAddr + 1;
      if ((regWdata & 32'h2A) != 0) w1cHits <= w1cHits + 1;
      if (nWr < 8) wrLog[nWr] <= regWdata;
      nWr <= nWr + 1;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct { logic [1:0] res; int ms; string req; } exp_t;
  exp_t expQ[$];
  int startCyc = 0;

  always @(negedge clk) begin
    if (rstN && done) begin
      if (expQ.size() == 0) chk(1'b0, "R9 unexpected done", 1, 0);
      else begin
        exp_t e;
        int lat;
        e = expQ.pop_front();
        lat = cycle - startCyc;
        chk(result == e.res, e.req, result, e.res);
        chk(lat >= e.ms * DIV && lat <= e.ms * DIV + SLACK,
            {e.req, " timing"}, lat, e.ms * DIV);
      end
    end
  end

  task automatic runCase(input int idx, input int pcd, input logic [31:0] s0,
                         input logic [31:0] s1, input logic [31:0] s2, input int len,
                         input logic [1:0] eRes, input int eMs, input string req,
                         input bit poke);
    exp_t e;
    @(posedge clk);
    script[0] = s0; script[1] = s1; script[2] = s2; script[3] = s2;
    scriptLen = len; pcdAt = pcd;
    portRds = 0; stsRds = 0; nWr = 0;
    badAddr = 0; overlap = 0; w1cHits = 0;
    expPortAddr = 12'(12'h44 + 4 * (idx - 1));
    e.res = eRes; e.ms = eMs; e.req = req;
    expQ.push_back(e);
    @(negedge clk);
    portIdx = 3'(idx); start = 1'b1; startCyc = cycle;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R9: a start during a run must not produce a second verdict
      repeat (40 * DIV) @(negedge clk);
      portIdx = 3'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (expQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && regRd == 1'b0 && regWr == 1'b0, "reset state", done, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1: rejected port numbers
    runCase(0, 1, 32'h1005, 32'h1005, 32'h1005, 1, 2'd2, 0, "R1 index zero", 1'b0);
    chk(portRds + stsRds + nWr == 0, "R1 no bus access", portRds + stsRds + nWr, 0);
    runCase(5, 1, 32'h1005, 32'h1005, 32'h1005, 1, 2'd2, 0, "R1 index too high", 1'b0);

    // R4/R3: success on first check, port 2, with a stray start mid-run (R9)
    runCase(2, 1, 32'h0000_102F, 32'h1005, 32'h1005, 2, 2'd0, 150, "R4 success", 1'b1);
    chk(nWr == 1, "R3 single write", nWr, 1);
    chk(wrLog[0] == 32'h0000_1101, "R3 assert write value", wrLog[0], 32'h1101);
    chk(badAddr == 0, "R3 port address", badAddr, 0);

    // R2: change-detect on third attempt, then success
    runCase(1, 3, 32'h1001, 32'h1005, 32'h1005, 2, 2'd0, 350, "R2 third attempt", 1'b0);
    chk(stsRds == 3, "R2 status reads", stsRds, 3);

    // R2: never a change-detect
    runCase(3, 0, 32'h1001, 32'h1005, 32'h1005, 2, 2'd1, 300, "R2 no change", 1'b0);
    chk(portRds + nWr == 0, "R2 port untouched", portRds + nWr, 0);

    // R5: disconnect wins over connect change
    runCase(4, 1, 32'h1001, 32'h1002, 32'h1002, 2, 2'd1, 150, "R5 disconnect", 1'b0);

    // R6: connect change while connected
    runCase(1, 1, 32'h1001, 32'h1003, 32'h1003, 2, 2'd2, 150, "R6 connect change", 1'b0);

    // R7: reset stuck once, release write, recovered on first recheck
    runCase(2, 1, 32'h1001, 32'h1109, 32'h1005, 3, 2'd0, 200, "R7 forced release", 1'b0);
    chk(nWr == 2, "R7 write count", nWr, 2);
    chk(wrLog[1] == 32'h0000_1001, "R7 release value", wrLog[1], 32'h1001);

    // R8: connected, never enabled -> busy after 500 ms of checks
    runCase(1, 1, 32'h1001, 32'h1001, 32'h1001, 2, 2'd3, 600, "R8 busy", 1'b0);
    chk(portRds == 11, "R8 check count", portRds, 11);

    // R7/R8: reset stuck forever -> repeated releases, then busy
    runCase(3, 1, 32'h1001, 32'h1101, 32'h1101, 2, 2'd3, 700, "R8 stuck busy", 1'b0);
    chk(nWr == 5, "R7 release per cycle", nWr, 5);
    chk(portRds == 13, "R7 recheck count", portRds, 13);
    chk(wrLog[4] == 32'h0000_1001, "R7 last release", wrLog[4], 32'h1001);
    chk(w1cHits == 0, "R3 no w1c bits written", w1cHits, 0);
    chk(overlap == 0, "R10 no overlapping access", overlap, 0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule